// File: doc/BRIEF.md
# Parallel Flash Request Controller

This block sits between a host and a small on-chip user flash array. The host uses three active-low strobes: read, write and erase. It also drives an address and write data. The block detects a falling edge on one strobe and captures the request. It then runs that single operation for a fixed number of clock cycles, and holds an active-low busy output low for that time. After a read, it presents the word and raises a data-valid flag. The storage model has two sectors of 16-bit words. Erasing a word sets it to all ones. Writing a word programs it flash-style, so bits can only go from one to zero.

The host address and data ports can be narrower than the internal 9-bit address and 16-bit data. A narrow address is left-justified and its low bits are padded with zeros. Narrow data is left-justified and its low bits are padded with ones. The top address bit selects the sector for an erase. The oscillator-enable output is tied asserted.

The FSM has four states. S_IDLE is the only state where a request is accepted. S_READ, S_WRITE and S_ERASE count down the cycle budget of their operation. The transitions are:
- ACCEPT: S_IDLE goes to the state of the strobe that fell, when that strobe is the only one low.
- REJECT: S_IDLE stays in S_IDLE when several strobes are low.
- HOLD: an operation state stays put while its counter is above zero.
- DONE: an operation state returns to S_IDLE when its counter reaches zero, and the operation is applied on that edge.

Top module: `pflash_req_ctrl`

## Requirements
- R1: A falling edge on rd_n, wr_n or er_n is accepted while busy_n is high, provided that strobe is the only one low. The edge starts a read, a write or an erase, respectively.
- R2: busy_n goes low on the clock edge that accepts a request. It stays low for exactly READ_CYCLES, WRITE_CYCLES or ERASE_CYCLES cycles, then returns high.
- R3: When a read completes, dout holds the stored word at the captured address and data_valid goes high.
- R4: If more than one strobe is low when a falling edge is seen, the request is dropped. busy_n stays high and the array is unchanged.
- R5: A strobe edge that occurs while busy_n is low is ignored and starts no operation.
- R6: A write stores the old word ANDed with the padded write data.
- R7: An erase sets every word of the sector chosen by internal address bit 8 (the user address MSB) to 16'hFFFF. The other sector is untouched.
- R8: The user address of USER_ADDR_W bits occupies internal address bits [8:9-USER_ADDR_W], and the remaining low bits are zero.
- R9: User data of USER_DATA_W bits occupies internal data bits [15:16-USER_DATA_W], and the remaining low bits are one. With width 12, data 12'h5A3 becomes 16'h5A3F.
- R10: data_valid clears on any accepted request and stays low through and after a write or an erase.
- R11: osc_en is 1 at all times.
- R12: After reset, busy_n is 1, data_valid is 0, dout is 0 and every array word is 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| er_n | input | 1 | Sector erase strobe, active low |
| addr | input | USER_ADDR_W | User word address |
| din | input | USER_DATA_W | User write data |
| dout | output | 16 | Read data, full internal width |
| busy_n | output | 1 | Low while an operation is running |
| data_valid | output | 1 | High when dout holds a completed read |
| osc_en | output | 1 | Oscillator enable, always high |

## Verification
The assertions check the following on every cycle:
- busy_n stays low while the countdown is non-zero.
- A request with more than one strobe low never drops busy_n.
- data_valid only rises out of a read.
- data_valid is already low when busy_n falls.
- The array is never written and erased in the same cycle.

Several behaviours need the storage contents and the exact busy duration, so only the bench scenarios can show them:
- flash-style AND programming;
- the ones-padding of narrow data;
- sector selection from the address MSB;
- the absence of any effect from conflicting or busy-time strobes.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
    localparam int IADDR_W = 9;
    localparam int IDATA_W = 16;
    localparam int WORDS   = 1 << IADDR_W;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2,
        S_ERASE = 2'd3
    } fsm_state_t;

    typedef enum logic [1:0] {
        OP_RD = 2'd0,
        OP_WR = 2'd1,
        OP_ER = 2'd2
    } op_kind_t;
endpackage

// File: rtl/pflash_strobe_det.sv
module pflash_strobe_det (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic                  er_n,
    output logic                  req_ok,
    output pflash_pkg::op_kind_t  req_op
);
    import pflash_pkg::*;

    logic [2:0] lvl_q;
    logic [2:0] low_now;
    logic [2:0] fell;

    assign low_now = {~er_n, ~wr_n, ~rd_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 3'b000;
        else        lvl_q <= low_now;
    end

    assign fell = low_now & ~lvl_q;

    // R1 / R4: accept only when exactly one strobe is low at the edge.
    always_comb begin
        req_ok = 1'b0;
        req_op = OP_RD;
        if (|fell) begin
            unique case (low_now)
                3'b001:  begin req_ok = 1'b1; req_op = OP_RD; end
                3'b010:  begin req_ok = 1'b1; req_op = OP_WR; end
                3'b100:  begin req_ok = 1'b1; req_op = OP_ER; end
                default: begin req_ok = 1'b0; req_op = OP_RD; end
            endcase
        end
    end
endmodule

// File: rtl/pflash_pad.sv
module pflash_pad #(
    parameter int IN_W   = 6,
    parameter int FULL_W = 9,
    parameter bit FILL   = 1'b0
) (
    input  logic [IN_W-1:0]   narrow,
    output logic [FULL_W-1:0] wide
);
    localparam int PAD_W = FULL_W - IN_W;

    generate
        if (PAD_W == 0) begin : g_full
            assign wide = narrow;
        end else begin : g_pad
            assign wide = {narrow, {PAD_W{FILL}}};
        end
    endgenerate
endmodule

// File: rtl/pflash_array.sv
module pflash_array (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [pflash_pkg::IADDR_W-1:0]  a,
    input  logic [pflash_pkg::IDATA_W-1:0]  wdata,
    input  logic                            wr_en,
    input  logic                            er_en,
    output logic [pflash_pkg::IDATA_W-1:0]  rdata
);
    import pflash_pkg::*;

    logic [IDATA_W-1:0] mem [WORDS];

    assign rdata = mem[a];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (er_en) begin
            for (int i = 0; i < WORDS; i++) begin
                if (i[IADDR_W-1] == a[IADDR_W-1]) mem[i] <= '1;   // R7
            end
        end else if (wr_en) begin
            mem[a] <= mem[a] & wdata;                              // R6
        end
    end

    a_r7_one_op_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && er_en))
        else $error("a_r7_one_op_per_cycle");
endmodule

// File: rtl/pflash_req_ctrl.sv
module pflash_req_ctrl #(
    parameter int USER_ADDR_W  = 6,
    parameter int USER_DATA_W  = 12,
    parameter int READ_CYCLES  = 2,
    parameter int WRITE_CYCLES = 4,
    parameter int ERASE_CYCLES = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_n,
    input  logic                   wr_n,
    input  logic                   er_n,
    input  logic [USER_ADDR_W-1:0] addr,
    input  logic [USER_DATA_W-1:0] din,
    output logic [15:0]            dout,
    output logic                   busy_n,
    output logic                   data_valid,
    output logic                   osc_en
);
    import pflash_pkg::*;

    localparam int MAX_CYC = (READ_CYCLES > WRITE_CYCLES)
                           ? ((READ_CYCLES > ERASE_CYCLES) ? READ_CYCLES : ERASE_CYCLES)
                           : ((WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES);
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    fsm_state_t          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic                req_ok;
    op_kind_t            req_op;
    logic [IADDR_W-1:0]  a_wide, a_q;
    logic [IDATA_W-1:0]  d_wide, d_q;
    logic [IDATA_W-1:0]  rdata;
    logic                accept, finish;

    pflash_strobe_det u_det (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .er_n(er_n),
        .req_ok(req_ok), .req_op(req_op)
    );

    pflash_pad #(.IN_W(USER_ADDR_W), .FULL_W(IADDR_W), .FILL(1'b0)) u_apad (   // R8
        .narrow(addr), .wide(a_wide)
    );

    pflash_pad #(.IN_W(USER_DATA_W), .FULL_W(IDATA_W), .FILL(1'b1)) u_dpad (   // R9
        .narrow(din), .wide(d_wide)
    );

    assign accept = (state_q == S_IDLE) && req_ok;     // R5: only in idle
    assign finish = (state_q != S_IDLE) && (cnt_q == '0);

    pflash_array u_arr (
        .clk(clk), .rst_n(rst_n), .a(a_q), .wdata(d_q),
        .wr_en(finish && state_q == S_WRITE),
        .er_en(finish && state_q == S_ERASE),
        .rdata(rdata)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    unique case (req_op)
                        OP_RD:   state_d = S_READ;
                        OP_WR:   state_d = S_WRITE;
                        default: state_d = S_ERASE;
                    endcase
                end
            end
            S_READ, S_WRITE, S_ERASE: begin
                if (cnt_q == '0) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register, countdown and request capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            a_q     <= '0;
            d_q     <= '1;
        end else begin
            state_q <= state_d;
            if (accept) begin
                a_q <= a_wide;
                d_q <= d_wide;
                unique case (req_op)
                    OP_RD:   cnt_q <= CNT_W'(READ_CYCLES - 1);
                    OP_WR:   cnt_q <= CNT_W'(WRITE_CYCLES - 1);
                    default: cnt_q <= CNT_W'(ERASE_CYCLES - 1);
                endcase
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Output register: read data and its valid flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout       <= '0;
            data_valid <= 1'b0;
        end else if (accept) begin
            data_valid <= 1'b0;                          // R10
        end else if (finish && state_q == S_READ) begin
            dout       <= rdata;                         // R3
            data_valid <= 1'b1;
        end
    end

    assign busy_n = (state_q == S_IDLE);
    assign osc_en = 1'b1;                                // R11

    a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && cnt_q != '0) |=> !busy_n)
        else $error("a_r2_busy_hold");

    a_r4_conflict_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && $countones({~rd_n, ~wr_n, ~er_n}) > 1) |=> busy_n)
        else $error("a_r4_conflict_reject");

    a_r3_valid_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> $past(state_q == S_READ))
        else $error("a_r3_valid_from_read");

    a_r10_valid_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> !data_valid)
        else $error("a_r10_valid_clear");
endmodule

// File: tb/pflash_req_ctrl_tb.sv
module pflash_req_ctrl_tb;
    localparam int AW = 6;
    localparam int DW = 12;
    localparam int RC = 2;
    localparam int WC = 4;
    localparam int EC = 6;
    localparam int OP_RD = 0;
    localparam int OP_WR = 1;
    localparam int OP_ER = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_n = 1'b1, wr_n = 1'b1, er_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [15:0] dout;
    logic busy_n, data_valid, osc_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pflash_req_ctrl #(.USER_ADDR_W(AW), .USER_DATA_W(DW), .READ_CYCLES(RC),
                      .WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .er_n(er_n),
        .addr(addr), .din(din), .dout(dout), .busy_n(busy_n),
        .data_valid(data_valid), .osc_en(osc_en)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One accepted operation. Checks busy timing (R2) and the data_valid clear (R10).
    task automatic run_op(int kind, logic [AW-1:0] a, logic [DW-1:0] d);
        int n;
        n = (kind == OP_RD) ? RC : (kind == OP_WR) ? WC : EC;
        @(negedge clk);
        addr = a; din = d;
        if (kind == OP_RD) rd_n = 1'b0;
        else if (kind == OP_WR) wr_n = 1'b0;
        else er_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 busy_n low on accept", {15'd0, busy_n}, 16'd0);
        chk("R10 data_valid cleared on accept", {15'd0, data_valid}, 16'd0);
        rd_n = 1'b1; wr_n = 1'b1; er_n = 1'b1;
        for (int i = 1; i < n; i++) begin
            @(posedge clk); #1;
        end
        chk("R2 busy_n still low at last op cycle", {15'd0, busy_n}, 16'd0);
        @(posedge clk); #1;
        chk("R2 busy_n high after op", {15'd0, busy_n}, 16'd1);
    endtask

    task automatic read_expect(string req, logic [AW-1:0] a, logic [15:0] exp);
        run_op(OP_RD, a, '0);
        chk("R3 data_valid after read", {15'd0, data_valid}, 16'd1);
        chk(req, dout, exp);
    endtask

    task automatic t_reset;
        chk("R12 busy_n after reset", {15'd0, busy_n}, 16'd1);
        chk("R12 data_valid after reset", {15'd0, data_valid}, 16'd0);
        chk("R12 dout after reset", dout, 16'h0000);
        chk("R11 osc_en", {15'd0, osc_en}, 16'd1);
        read_expect("R12 array erased at reset", 6'd5, 16'hFFFF);
    endtask

    task automatic t_write_program;
        run_op(OP_WR, 6'd5, 12'h5A3);
        chk("R10 data_valid low after write", {15'd0, data_valid}, 16'd0);
        read_expect("R9 ones padding of data", 6'd5, 16'h5A3F);
        run_op(OP_WR, 6'd5, 12'hF0F);
        read_expect("R6 AND programming", 6'd5, 16'h5A3F & 16'hF0FF);
        run_op(OP_WR, 6'h25, 12'h000);
        read_expect("R6 sector1 write", 6'h25, 16'h000F);
        read_expect("R8 distinct word untouched", 6'd6, 16'hFFFF);
    endtask

    task automatic t_erase;
        run_op(OP_ER, 6'h20, '0);
        chk("R10 data_valid low after erase", {15'd0, data_valid}, 16'd0);
        read_expect("R7 sector1 erased", 6'h25, 16'hFFFF);
        read_expect("R7 sector0 kept", 6'd5, 16'h503F);
        run_op(OP_ER, 6'h00, '0);
        read_expect("R7 sector0 erased", 6'd5, 16'hFFFF);
    endtask

    task automatic t_conflict;
        @(negedge clk);
        addr = 6'd5; din = 12'h000;
        rd_n = 1'b0; wr_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk("R4 conflict keeps busy_n high", {15'd0, busy_n}, 16'd1);
        end
        rd_n = 1'b1; wr_n = 1'b1;
        @(posedge clk); #1;
        chk("R4 release starts nothing", {15'd0, busy_n}, 16'd1);
        read_expect("R4 word unchanged by conflict", 6'd5, 16'hFFFF);
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        addr = 6'd7; din = 12'h000; wr_n = 1'b0;
        @(posedge clk); #1;
        wr_n = 1'b1;
        @(posedge clk); #1;
        er_n = 1'b0; addr = 6'd0;
        @(posedge clk); #1;
        er_n = 1'b1;
        @(posedge clk); #1;
        chk("R5 busy_n low mid write", {15'd0, busy_n}, 16'd0);
        @(posedge clk); #1;
        chk("R5 write ends on time", {15'd0, busy_n}, 16'd1);
        @(posedge clk); #1;
        chk("R5 no late erase", {15'd0, busy_n}, 16'd1);
        read_expect("R5 erase during busy ignored", 6'd7, 16'h000F);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_write_program();
        t_erase();
        t_conflict();
        t_busy_ignore();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule